// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block produces the SCL waveform timing for an I2C master from the peripheral clock. It assembles an 11-bit period code from two configuration fields, then alternates a driven-low phase and a released-high phase whose lengths come from that code. Two timing modes exist: a standard mode with near-equal low and high phases, and a fast mode where the low phase is about twice the high phase. A separate prescale code marks slow peripheral clocks; in standard mode, a slow clock adds a fixed extra delay to each phase. This compensates for the constant that software takes off the code for such clocks.

The generator pulls SCL low itself. After it releases the line, it waits until the line is seen high through a synchronizer before it counts the high phase, so a slave that holds SCL low stretches the period. For the byte controller it emits four single-cycle marker pulses. These mark the SCL fall, the point where SDA may change, the last low cycle before release, and the middle of the high phase where data is sampled. Clearing the enable bit, which includes writing both configuration fields to zero, returns the generator to idle at the next edge.

Top module: `scl_rate_gen`

## Requirements
- R1: The period code N is `{clk_hi_cfg[5:0], clk_lo_cfg[4:0]}`, with the high-order six bits taken from the high configuration field.
- R2: While `clk_lo_cfg[5]` (enable) is 0, from the next clock on `scl_drive_low` is 0 and no tick pulses appear.
- R3: With `clk_lo_cfg[6]` = 0 (standard mode), the low phase lasts N+3 cycles and the counted high phase lasts N+1 cycles.
- R4: With `clk_lo_cfg[6]` = 1 (fast mode), the low phase lasts N+3 cycles and the counted high phase lasts floor(N/2)+1 cycles.
- R5: In standard mode, when `presc_code` is 0 or 1, each phase is 65 cycles longer. Fast mode and prescale codes of 2 or more get no extra delay.
- R6: After release, the high phase starts counting only once `scl_in` has been seen high through a two-stage synchronizer. On a free line, 3 cycles pass between the last low cycle and the first counted high cycle. Each extra cycle a slave holds SCL low lengthens the period by one.
- R7: `tick_fall` marks the first low cycle, `tick_sda` the low cycle at offset floor(low/2), `tick_rise` the last low cycle, and `tick_sample` the high cycle at offset floor(high/2). Each pulse lasts one cycle and at most one is high per cycle.
- R8: When enable goes from 0 to 1, the next cycle is the first low cycle, with `tick_fall` high.
- R9: During and straight after reset, `scl_drive_low` and all ticks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_lo_cfg | input | 7 | [4:0] low code bits, [5] enable, [6] fast mode |
| clk_hi_cfg | input | 6 | Upper six bits of the period code |
| presc_code | input | 5 | Peripheral clock prescale code |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| tick_fall | output | 1 | First cycle of the low phase |
| tick_sda | output | 1 | SDA change point within the low phase |
| tick_rise | output | 1 | Last low cycle before release |
| tick_sample | output | 1 | Data sample point within the high phase |

## Verification
A wrong phase counter or a wrong length decode moves `tick_sda`, `tick_rise` or the release of `scl_drive_low` away from its expected cycle. This shows within one SCL period, so the per-cycle comparison against the reference model catches it at the first differing cycle. A synchronizer that is too short or skipped makes the release-to-high gap shorter than three cycles, and this shows on the first high phase. A state that does not return to idle shows as a driven line or a stray tick one cycle after enable drops.

// File: rtl/scl_gen_pkg.sv
// Package: shared phase encoding for the SCL rate generator.
// Assumes: consumers only compare against these names, never raw codes.
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_line_sync.sv
// Module: scl_line_sync
// Brings the external SCL level into the clock domain through a chain of
// flops. Assumes the released line idles high, so every stage resets to 1.
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw line level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_in;
                end
            end else begin : g_next
                // Pass the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign line_sync = chain_q[STAGES-1];

endmodule

// File: rtl/scl_phase_len.sv
// Module: scl_phase_len
// Turns the split period code, the mode bit and the prescale code into
// phase lengths and marker offsets. Pure combinational logic.
// Assumes CNT_W is wide enough for the code plus SLOW_EXTRA plus 3.
module scl_phase_len #(
    parameter int CODE_LO_W  = 5,
    parameter int CODE_HI_W  = 6,
    parameter int PRESC_W    = 5,
    parameter int SLOW_EXTRA = 65,
    parameter int SLOW_PRESC = 1,
    parameter int CNT_W      = CODE_LO_W + CODE_HI_W + 2
) (
    input  logic [CODE_LO_W-1:0] code_lo,
    input  logic [CODE_HI_W-1:0] code_hi,
    input  logic                 fast_mode,
    input  logic [PRESC_W-1:0]   presc,
    output logic [CNT_W-1:0]     low_len,
    output logic [CNT_W-1:0]     high_len,
    output logic [CNT_W-1:0]     sda_pt,
    output logic [CNT_W-1:0]     sample_pt
);

    localparam int CODE_W = CODE_LO_W + CODE_HI_W;

    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  code_ext;
    logic [CNT_W-1:0]  extra;
    logic              slow_clk;

    assign code     = {code_hi, code_lo};
    assign code_ext = CNT_W'(code);
    assign slow_clk = (presc <= PRESC_W'(SLOW_PRESC));

    // Select the compensation delay for slow clocks in standard mode.
    always_comb begin
        extra = '0;
        if (!fast_mode && slow_clk) extra = CNT_W'(SLOW_EXTRA);
    end

    // Derive both phase lengths from the code and the mode.
    always_comb begin
        low_len = code_ext + CNT_W'(3) + extra;
        if (fast_mode) high_len = (code_ext >> 1) + CNT_W'(1);
        else           high_len = code_ext + CNT_W'(1) + extra;
    end

    // Place the SDA change and sample markers mid-phase.
    always_comb begin
        sda_pt    = low_len >> 1;
        sample_pt = high_len >> 1;
    end

endmodule

// File: rtl/scl_phase_fsm.sv
// Module: scl_phase_fsm
// Sequences idle, low, wait-for-high and high phases and emits marker
// pulses. Assumes low_len >= 3 and high_len >= 1 (guaranteed by
// scl_phase_len), and that line_high is already synchronized.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             line_high,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic [CNT_W-1:0] sda_pt,
    input  logic [CNT_W-1:0] sample_pt,
    output logic             drive_low,
    output logic             pulse_fall,
    output logic             pulse_sda,
    output logic             pulse_rise,
    output logic             pulse_sample
);

    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             low_done, high_done;

    assign low_done  = (cnt_q >= low_len - CNT_W'(1));
    assign high_done = (cnt_q >= high_len - CNT_W'(1));

    // Choose the next phase and counter value.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (!run) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_LOW;
                    cnt_d   = '0;
                end
                PH_LOW: begin
                    if (low_done) begin
                        phase_d = PH_WAIT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                PH_WAIT: begin
                    if (line_high) begin
                        phase_d = PH_HIGH;
                        cnt_d   = '0;
                    end
                end
                PH_HIGH: begin
                    if (high_done) begin
                        phase_d = PH_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Register phase and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Decode line drive and marker pulses from the registered state.
    always_comb begin
        drive_low    = (phase_q == PH_LOW);
        pulse_fall   = (phase_q == PH_LOW) && (cnt_q == '0);
        pulse_sda    = (phase_q == PH_LOW) && (cnt_q == sda_pt);
        pulse_rise   = (phase_q == PH_LOW) && (cnt_q == low_len - CNT_W'(1));
        pulse_sample = (phase_q == PH_HIGH) && (cnt_q == sample_pt);
    end

endmodule

// File: rtl/scl_rate_gen.sv
// Module: scl_rate_gen (top)
// SCL rate generator: splits the configuration fields, computes phase
// lengths, synchronizes the line and runs the phase sequencer.
// Assumes scl_in reflects the wired-AND level of the SCL line.
module scl_rate_gen #(
    parameter int CODE_LO_W   = 5,
    parameter int CODE_HI_W   = 6,
    parameter int PRESC_W     = 5,
    parameter int SLOW_EXTRA  = 65,
    parameter int SLOW_PRESC  = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CODE_LO_W+1:0] clk_lo_cfg,
    input  logic [CODE_HI_W-1:0] clk_hi_cfg,
    input  logic [PRESC_W-1:0]   presc_code,
    input  logic                 scl_in,
    output logic                 scl_drive_low,
    output logic                 tick_fall,
    output logic                 tick_sda,
    output logic                 tick_rise,
    output logic                 tick_sample
);

    localparam int EN_BIT   = CODE_LO_W;
    localparam int FAST_BIT = CODE_LO_W + 1;
    localparam int CNT_W    = CODE_LO_W + CODE_HI_W + 2;

    logic             line_high;
    logic [CNT_W-1:0] low_len, high_len, sda_pt, sample_pt;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_sync (line_high)
    );

    scl_phase_len #(
        .CODE_LO_W  (CODE_LO_W),
        .CODE_HI_W  (CODE_HI_W),
        .PRESC_W    (PRESC_W),
        .SLOW_EXTRA (SLOW_EXTRA),
        .SLOW_PRESC (SLOW_PRESC),
        .CNT_W      (CNT_W)
    ) u_len (
        .code_lo   (clk_lo_cfg[CODE_LO_W-1:0]),
        .code_hi   (clk_hi_cfg),
        .fast_mode (clk_lo_cfg[FAST_BIT]),
        .presc     (presc_code),
        .low_len   (low_len),
        .high_len  (high_len),
        .sda_pt    (sda_pt),
        .sample_pt (sample_pt)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (clk_lo_cfg[EN_BIT]),
        .line_high    (line_high),
        .low_len      (low_len),
        .high_len     (high_len),
        .sda_pt       (sda_pt),
        .sample_pt    (sample_pt),
        .drive_low    (scl_drive_low),
        .pulse_fall   (tick_fall),
        .pulse_sda    (tick_sda),
        .pulse_rise   (tick_rise),
        .pulse_sample (tick_sample)
    );

endmodule

// File: rtl/scl_rate_gen_chk.sv
// Module: scl_rate_gen_chk
// Port-level protocol checks for scl_rate_gen, attached by bind.
module scl_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_drive_low,
    input logic tick_fall,
    input logic tick_sda,
    input logic tick_rise,
    input logic tick_sample
);

    logic any_tick;
    assign any_tick = tick_fall | tick_sda | tick_rise | tick_sample;

    p_ticks_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tick_fall, tick_sda, tick_rise, tick_sample}));

    p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !any_tick));

    p_fall_is_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fall |-> scl_drive_low);

    p_release_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !scl_drive_low);

    p_sample_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sample |-> !scl_drive_low);

    p_low_starts_with_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> tick_fall);

endmodule

bind scl_rate_gen scl_rate_gen_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (clk_lo_cfg[5]),
    .scl_drive_low (scl_drive_low),
    .tick_fall     (tick_fall),
    .tick_sda      (tick_sda),
    .tick_rise     (tick_rise),
    .tick_sample   (tick_sample)
);

// File: tb/scl_rate_gen_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed
// period and marker-offset measurements.
module scl_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] lo_cfg = '0;
    logic [5:0] hi_cfg = '0;
    logic [4:0] presc = 5'd3;
    logic       slave_hold = 1'b0;
    logic       scl_line;
    logic       drv, t_fall, t_sda, t_rise, t_samp;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R9";

    always #5 clk = ~clk;

    assign scl_line = !drv && !slave_hold;

    scl_rate_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_lo_cfg    (lo_cfg),
        .clk_hi_cfg    (hi_cfg),
        .presc_code    (presc),
        .scl_in        (scl_line),
        .scl_drive_low (drv),
        .tick_fall     (t_fall),
        .tick_sda      (t_sda),
        .tick_rise     (t_rise),
        .tick_sample   (t_samp)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_phase = 0;   // 0 idle, 1 low, 2 wait, 3 high
    int m_cnt   = 0;
    bit m_s0 = 1'b1, m_s1 = 1'b1;
    bit cmp_on = 1'b0;

    function automatic int ref_low();
        int n = hi_cfg * 32 + lo_cfg[4:0];
        int ex = (!lo_cfg[6] && presc <= 1) ? 65 : 0;
        return n + 3 + ex;
    endfunction

    function automatic int ref_high();
        int n = hi_cfg * 32 + lo_cfg[4:0];
        int ex = (!lo_cfg[6] && presc <= 1) ? 65 : 0;
        return lo_cfg[6] ? (n / 2 + 1) : (n + 1 + ex);
    endfunction

    always @(posedge clk) begin
        int lo_l, hi_l;
        lo_l = ref_low();
        hi_l = ref_high();
        if (!rst_n) begin
            m_phase <= 0; m_cnt <= 0; m_s0 <= 1'b1; m_s1 <= 1'b1;
        end else begin
            m_s0 <= scl_line;
            m_s1 <= m_s0;
            if (!lo_cfg[5]) begin
                m_phase <= 0; m_cnt <= 0;
            end else if (m_phase == 0) begin
                m_phase <= 1; m_cnt <= 0;
            end else if (m_phase == 1) begin
                if (m_cnt >= lo_l - 1) begin m_phase <= 2; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end else if (m_phase == 2) begin
                if (m_s1) begin m_phase <= 3; m_cnt <= 0; end
            end else begin
                if (m_cnt >= hi_l - 1) begin m_phase <= 1; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    // Compare all outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            int lo_l, hi_l;
            lo_l = ref_low();
            hi_l = ref_high();
            check(cur_req, "drive", int'(drv), int'(m_phase == 1));
            check(cur_req, "fall", int'(t_fall), int'(m_phase == 1 && m_cnt == 0));
            check(cur_req, "sda", int'(t_sda), int'(m_phase == 1 && m_cnt == lo_l / 2));
            check(cur_req, "rise", int'(t_rise), int'(m_phase == 1 && m_cnt == lo_l - 1));
            check(cur_req, "sample", int'(t_samp), int'(m_phase == 3 && m_cnt == hi_l / 2));
        end
    end

    // Measure one period from a fall tick, with marker offsets.
    task automatic measure(input string req, input int e_per, input int e_sda,
                           input int e_rise, input int e_samp, input int hold_k);
        int n = 0, o_sda = -1, o_rise = -1, o_samp = -1;
        do @(negedge clk); while (!t_fall);
        do begin
            if (t_sda)  o_sda  = n;
            if (t_rise) begin
                o_rise = n;
                if (hold_k > 0) begin
                    slave_hold = 1'b1;
                    for (int k = 0; k < hold_k; k++) begin
                        @(negedge clk); n++;
                        if (t_samp) o_samp = n;
                    end
                    slave_hold = 1'b0;
                end
            end
            if (t_samp) o_samp = n;
            @(negedge clk); n++;
        end while (!t_fall);
        check(req, "period", n, e_per);
        check(req, "sda offset", o_sda, e_sda);
        check(req, "rise offset", o_rise, e_rise);
        check(req, "sample offset", o_samp, e_samp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R9: reset state
        check("R9", "drive in reset", int'(drv), 0);
        check("R9", "ticks in reset", int'(t_fall | t_sda | t_rise | t_samp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "drive after reset", int'(drv), 0);

        // R2: disabled with a nonzero code
        cur_req = "R2";
        lo_cfg = 7'b0_0_01010;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R2", "disabled drive", int'(drv), 0);
            check("R2", "disabled ticks", int'(t_fall | t_sda | t_rise | t_samp), 0);
        end

        // R8: enable starts a low phase on the next cycle
        cur_req = "R8";
        lo_cfg = 7'b0_1_01010;
        @(negedge clk);
        check("R8", "fall after enable", int'(t_fall), 1);
        check("R8", "drive after enable", int'(drv), 1);

        // R3: standard mode N=10
        cur_req = "R3";
        measure("R3", 27, 6, 12, 21, 0);

        // R6: slave stretch of 10 cycles
        cur_req = "R6";
        measure("R6", 36, 6, 12, 30, 10);
        measure("R6", 27, 6, 12, 21, 0);

        // R4: fast mode N=10
        cur_req = "R4";
        lo_cfg = 7'b1_1_01010;
        measure("R4", 22, 6, 12, 19, 0);

        // R5: slow clock, standard adds delay, fast does not
        cur_req = "R5";
        presc = 5'd1;
        lo_cfg = 7'b0_1_00000;
        measure("R5", 137, 34, 67, 104, 0);
        presc = 5'd0;
        measure("R5", 137, 34, 67, 104, 0);
        lo_cfg = 7'b1_1_00000;
        measure("R5", 7, 1, 2, 6, 0);

        // R1: upper code bits from the high field, N=32
        cur_req = "R1";
        presc = 5'd3;
        hi_cfg = 6'd1;
        lo_cfg = 7'b0_1_00000;
        measure("R1", 71, 17, 34, 54, 0);

        // R2/R8: disable mid-run, then both fields zero
        cur_req = "R2";
        repeat (5) @(negedge clk);
        lo_cfg = 7'b0_0_00000;
        hi_cfg = 6'd0;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            check("R2", "zeroed drive", int'(drv), 0);
            check("R2", "zeroed ticks", int'(t_fall | t_sda | t_rise | t_samp), 0);
            @(negedge clk);
        end
        cur_req = "R7";
        lo_cfg = 7'b0_1_00011;
        @(negedge clk);
        check("R8", "restart fall", int'(t_fall), 1);
        // R7: marker placement at N=3 standard: low 6, high 4
        measure("R7", 13, 3, 5, 11, 0);

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule